// File: doc/BRIEF.md
# Word-Organized Program Memory Byte Load Unit

This unit carries out one instruction of a small 8-bit processor: it loads a single byte from program memory into a general register. Program memory is built from 16-bit words, but the pointer that selects the data counts bytes. The byte pointer is 24 bits wide. Its upper 8 bits come from an extension register. Its lower 16 bits come from the register pair r31 (high byte) and r30 (low byte). The unit recognizes three opcode forms. One form writes r0 as an implied destination. One writes any register Rd. The third writes Rd and then adds one to the whole 24-bit pointer.

Opcodes enter on a valid/ready stream. `op_ready` is high only while the unit is idle, and a transfer happens on a clock edge where `op_valid` and `op_ready` are both high. While `op_valid` is high and `op_ready` is low, the producer must hold `op_code` steady. The unit has no buffer at its input, so a refused opcode simply waits. The unit reads r31:r30 and the extension register through plain read ports. It fetches one word through a program-memory port whose data arrives one cycle after the request. It returns results through three register write ports and an extension write port. A legal instruction takes three cycles after acceptance, ending with a one-cycle `done`. No status flag is touched.

Top module: `pmload_unit`

## Requirements
- R1: `op_ready` is high exactly when `busy` is low. After reset the unit is idle. An opcode is accepted on an edge with `op_valid` and `op_ready` both high. For a legal opcode, `busy` then stays high for exactly 3 cycles, and for an illegal one for exactly 1 cycle.
- R2: Opcode 0x95D8 loads the addressed byte into r0 and leaves r30, r31 and the extension register unchanged.
- R3: An opcode matching (op & 0xFE0F) == 0x9006 loads the addressed byte into the register numbered by op[8:4] and leaves the pointer unchanged.
- R4: An opcode matching (op & 0xFE0F) == 0x9007 loads the addressed byte into the register numbered by op[8:4].
- R5: The byte address is {ext, r31, r30}. In the second cycle after acceptance, `pm_req` is high and `pm_addr` carries the byte address shifted right by one. `pm_rdata` is taken in the following cycle.
- R6: Byte-address bit 0 picks the byte: 0 selects `pm_rdata[7:0]` and 1 selects `pm_rdata[15:8]`.
- R7: In the post-increment form, the 24-bit value {ext, r31, r30} plus one is written back in the `done` cycle, with carries crossing into the extension register. 0xFFFFFF wraps to 0x000000.
- R8: In the `done` cycle, write port 0 carries the loaded byte, port 1 carries the new r30 and port 2 carries the new r31. The register file applies the ports in index order, so a pointer write overrides the byte on the same register. `undef` pulses with `done` when the post-increment form targets r30 or r31.
- R9: Any other opcode raises `illegal` for the one cycle after acceptance. It makes no register write, no extension write, no memory request and no `done`.
- R10: `done` is a single-cycle pulse in the third cycle after acceptance, and all writes of the instruction happen in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode stream valid |
| op_ready | output | 1 | Opcode stream ready (unit idle) |
| op_code | input | 16 | Opcode word |
| busy | output | 1 | Instruction in progress |
| rf_rd_en | output | 1 | Pointer read strobe (decode cycle) |
| rf_raddr_lo | output | 5 | Read address of pointer low register (30) |
| rf_raddr_hi | output | 5 | Read address of pointer high register (31) |
| rf_rdata_lo | input | 8 | Pointer low byte read data |
| rf_rdata_hi | input | 8 | Pointer high byte read data |
| ext_rdata | input | 8 | Extension register value |
| pm_req | output | 1 | Program-memory word read request |
| pm_addr | output | 23 | Program-memory word address |
| pm_rdata | input | 16 | Program-memory word, one cycle after request |
| rf_we | output | 3 | Write enables, port 0 byte, port 1 r30, port 2 r31 |
| rf_waddr | output | 15 | Write addresses, 5 bits per port, port 0 in bits 4:0 |
| rf_wdata | output | 24 | Write data, 8 bits per port, port 0 in bits 7:0 |
| ext_we | output | 1 | Extension register write enable |
| ext_wdata | output | 8 | Extension register write data |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Unrecognized opcode pulse |
| undef | output | 1 | Post-increment targeting r30 or r31 |

## Verification
The two functions that can land in one cycle are the byte load into Rd and the pointer write-back. They collide when the post-increment form names r30 or r31, so the same register receives two writes at the same edge. The bench triggers this with destination 30 and 31, and also with pointers at 0x..FFFF, where the carry reaches the extension register in that same cycle. A behavioural register-file model applies the byte first and then the pointer. Its contents and extension value are compared with the environment's after every instruction, and `undef` is checked on every clock.

// File: rtl/pmload_pkg.sv
`timescale 1ns/1ps
package pmload_pkg;

  localparam int unsigned REG_AW = 5;

  // Opcode encodings; the destination field sits in bits 8:4.
  localparam logic [15:0] OPC_IMPLIED   = 16'h95D8;
  localparam logic [15:0] OPC_FORM_MASK = 16'hFE0F;
  localparam logic [15:0] OPC_KEEP      = 16'h9006;
  localparam logic [15:0] OPC_POSTINC   = 16'h9007;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_DECODE,
    SQ_FETCH,
    SQ_WRITE
  } sq_state_e;

  typedef enum logic [1:0] {
    LD_NONE,
    LD_IMPLIED,
    LD_KEEP,
    LD_POSTINC
  } ld_form_e;

  typedef struct packed {
    ld_form_e           form;
    logic [REG_AW-1:0]  dst;
  } ld_dec_t;

endpackage

// File: rtl/pmload_decode.sv
`timescale 1ns/1ps
module pmload_decode
  import pmload_pkg::*;
(
  input  logic [15:0] opcode,
  output ld_dec_t     dec,
  output logic        legal
);

  always_comb begin
    dec.form = LD_NONE;
    dec.dst  = opcode[8:4];
    if (opcode == OPC_IMPLIED) begin
      dec.form = LD_IMPLIED;
      dec.dst  = '0;
    end else if ((opcode & OPC_FORM_MASK) == OPC_KEEP) begin
      dec.form = LD_KEEP;
    end else if ((opcode & OPC_FORM_MASK) == OPC_POSTINC) begin
      dec.form = LD_POSTINC;
    end
  end

  assign legal = (dec.form != LD_NONE);

endmodule

// File: rtl/pmload_ptr.sv
`timescale 1ns/1ps
module pmload_ptr #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BYTE_AW = 24
) (
  input  logic [BYTE_AW-1:0]  byte_addr,
  input  logic [2*DATA_W-1:0] word,
  output logic [BYTE_AW-2:0]  word_addr,
  output logic [DATA_W-1:0]   byte_sel,
  output logic [BYTE_AW-1:0]  byte_addr_inc
);

  localparam int unsigned WORD_W = 2 * DATA_W;

  // Word index drops the lane-select bit.
  assign word_addr = byte_addr[BYTE_AW-1:1];

  // Lane 0 is the low half of the word, lane 1 the high half.
  assign byte_sel = byte_addr[0] ? word[WORD_W-1:DATA_W] : word[DATA_W-1:0];

  // Full-width increment; the carry runs into the extension bits and
  // the all-ones value rolls over to zero.
  assign byte_addr_inc = byte_addr + BYTE_AW'(1);

endmodule

// File: rtl/pmload_seq.sv
`timescale 1ns/1ps
module pmload_seq
  import pmload_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PTR_W      = 16,
  parameter int unsigned EXT_W      = 8,
  parameter int unsigned PTR_LO_IDX = 30,
  parameter int unsigned PTR_HI_IDX = 31
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            op_valid,
  output logic                            op_ready,
  input  logic [15:0]                     op_code,
  output logic                            busy,
  output logic [15:0]                     op_q,
  input  ld_dec_t                         dec,
  input  logic                            legal,
  output logic                            rf_rd_en,
  input  logic [DATA_W-1:0]               rf_rdata_lo,
  input  logic [DATA_W-1:0]               rf_rdata_hi,
  input  logic [EXT_W-1:0]                ext_rdata,
  output logic [EXT_W+PTR_W-1:0]          baddr_q,
  input  logic [EXT_W+PTR_W-2:0]          word_addr,
  input  logic [DATA_W-1:0]               byte_sel,
  input  logic [EXT_W+PTR_W-1:0]          baddr_inc,
  output logic                            pm_req,
  output logic [EXT_W+PTR_W-2:0]          pm_addr,
  output logic [2:0]                      rf_we,
  output logic [3*REG_AW-1:0]             rf_waddr,
  output logic [3*DATA_W-1:0]             rf_wdata,
  output logic                            ext_we,
  output logic [EXT_W-1:0]                ext_wdata,
  output logic                            done,
  output logic                            illegal,
  output logic                            undef
);

  localparam int unsigned BYTE_AW = EXT_W + PTR_W;
  localparam logic [REG_AW-1:0] LO_A = REG_AW'(PTR_LO_IDX);
  localparam logic [REG_AW-1:0] HI_A = REG_AW'(PTR_HI_IDX);

  sq_state_e state_q;
  ld_dec_t   dec_q;
  logic      fire;
  logic      is_inc;

  assign op_ready = (state_q == SQ_IDLE);
  assign busy     = ~op_ready;
  assign fire     = op_valid & op_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      op_q    <= '0;
      dec_q   <= '{form: LD_NONE, dst: '0};
      baddr_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (fire) begin
            op_q    <= op_code;
            state_q <= SQ_DECODE;
          end
        end
        SQ_DECODE: begin
          if (legal) begin
            dec_q   <= dec;
            baddr_q <= {ext_rdata, rf_rdata_hi, rf_rdata_lo};
            state_q <= SQ_FETCH;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        SQ_FETCH: state_q <= SQ_WRITE;
        SQ_WRITE: state_q <= SQ_IDLE;
        default:  state_q <= SQ_IDLE;
      endcase
    end
  end

  assign is_inc   = (dec_q.form == LD_POSTINC);
  assign rf_rd_en = (state_q == SQ_DECODE);
  assign illegal  = (state_q == SQ_DECODE) & ~legal;
  assign pm_req   = (state_q == SQ_FETCH);
  assign pm_addr  = word_addr;
  assign done     = (state_q == SQ_WRITE);

  // Port 0: loaded byte; port 1: pointer low; port 2: pointer high.
  assign rf_waddr  = {HI_A, LO_A, dec_q.dst};
  assign rf_wdata  = {baddr_inc[PTR_W-1:DATA_W], baddr_inc[DATA_W-1:0], byte_sel};
  assign ext_wdata = baddr_inc[BYTE_AW-1:PTR_W];

  always_comb begin
    rf_we  = 3'b000;
    ext_we = 1'b0;
    undef  = 1'b0;
    if (state_q == SQ_WRITE) begin
      rf_we[0] = 1'b1;
      if (is_inc) begin
        rf_we[2:1] = 2'b11;
        ext_we     = 1'b1;
        undef      = (dec_q.dst == LO_A) || (dec_q.dst == HI_A);
      end
    end
  end

  // R1: an accepted opcode makes the unit busy on the next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> busy);

  // R5: a completion is always preceded by a memory request
  a_r5_fetch_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pm_req));

  // R10: done never lasts two cycles
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: an unrecognized opcode leaves every write port and the memory quiet
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (rf_we == 3'b000 && !ext_we && !pm_req && !done));

  // R8: the undefined flag only appears alongside the pointer write-back
  a_r8_undef_with_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (done && ext_we && rf_we[2]));

  // R7: extension write-back always travels with both pointer halves
  a_r7_ptr_wb_whole: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> (rf_we == 3'b111));

  // R1: the read strobe follows acceptance by exactly one cycle
  a_r1_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> $past(op_valid && op_ready));

endmodule

// File: rtl/pmload_unit.sv
`timescale 1ns/1ps
module pmload_unit
  import pmload_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PTR_W      = 16,
  parameter int unsigned EXT_W      = 8,
  parameter int unsigned PTR_LO_IDX = 30,
  parameter int unsigned PTR_HI_IDX = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  output logic                       op_ready,
  input  logic [15:0]                op_code,
  output logic                       busy,
  output logic                       rf_rd_en,
  output logic [4:0]                 rf_raddr_lo,
  output logic [4:0]                 rf_raddr_hi,
  input  logic [7:0]                 rf_rdata_lo,
  input  logic [7:0]                 rf_rdata_hi,
  input  logic [7:0]                 ext_rdata,
  output logic                       pm_req,
  output logic [22:0]                pm_addr,
  input  logic [15:0]                pm_rdata,
  output logic [2:0]                 rf_we,
  output logic [14:0]                rf_waddr,
  output logic [23:0]                rf_wdata,
  output logic                       ext_we,
  output logic [7:0]                 ext_wdata,
  output logic                       done,
  output logic                       illegal,
  output logic                       undef
);

  localparam int unsigned BYTE_AW = EXT_W + PTR_W;

  logic [15:0]        op_q;
  ld_dec_t            dec;
  logic               legal;
  logic [BYTE_AW-1:0] baddr_q;
  logic [BYTE_AW-2:0] word_addr;
  logic [DATA_W-1:0]  byte_sel;
  logic [BYTE_AW-1:0] baddr_inc;

  assign rf_raddr_lo = REG_AW'(PTR_LO_IDX);
  assign rf_raddr_hi = REG_AW'(PTR_HI_IDX);

  pmload_decode u_decode (
    .opcode (op_q),
    .dec    (dec),
    .legal  (legal)
  );

  pmload_ptr #(
    .DATA_W  (DATA_W),
    .BYTE_AW (BYTE_AW)
  ) u_ptr (
    .byte_addr     (baddr_q),
    .word          (pm_rdata),
    .word_addr     (word_addr),
    .byte_sel      (byte_sel),
    .byte_addr_inc (baddr_inc)
  );

  pmload_seq #(
    .DATA_W     (DATA_W),
    .PTR_W      (PTR_W),
    .EXT_W      (EXT_W),
    .PTR_LO_IDX (PTR_LO_IDX),
    .PTR_HI_IDX (PTR_HI_IDX)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_ready    (op_ready),
    .op_code     (op_code),
    .busy        (busy),
    .op_q        (op_q),
    .dec         (dec),
    .legal       (legal),
    .rf_rd_en    (rf_rd_en),
    .rf_rdata_lo (rf_rdata_lo),
    .rf_rdata_hi (rf_rdata_hi),
    .ext_rdata   (ext_rdata),
    .baddr_q     (baddr_q),
    .word_addr   (word_addr),
    .byte_sel    (byte_sel),
    .baddr_inc   (baddr_inc),
    .pm_req      (pm_req),
    .pm_addr     (pm_addr),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .ext_we      (ext_we),
    .ext_wdata   (ext_wdata),
    .done        (done),
    .illegal     (illegal),
    .undef       (undef)
  );

endmodule

// File: tb/pmload_unit_tb_top.sv
`timescale 1ns/1ps
module pmload_unit_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        op_valid = 1'b0;
  logic [15:0] op_code = '0;
  logic        op_ready, busy, rf_rd_en, pm_req, ext_we, done, illegal, undef;
  logic [4:0]  rf_raddr_lo, rf_raddr_hi;
  logic [7:0]  rf_rdata_lo, rf_rdata_hi, ext_reg, ext_wdata;
  logic [22:0] pm_addr;
  logic [15:0] pm_rdata;
  logic [2:0]  rf_we;
  logic [14:0] rf_waddr;
  logic [23:0] rf_wdata;

  logic [7:0]  rf [32];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_lo = '0, pre_hi = '0, pre_ext = '0;

  int n_run = 0;
  int n_fail = 0;
  bit timeout = 1'b0;

  pmload_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .busy(busy), .rf_rd_en(rf_rd_en),
    .rf_raddr_lo(rf_raddr_lo), .rf_raddr_hi(rf_raddr_hi),
    .rf_rdata_lo(rf_rdata_lo), .rf_rdata_hi(rf_rdata_hi), .ext_rdata(ext_reg),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .ext_we(ext_we), .ext_wdata(ext_wdata),
    .done(done), .illegal(illegal), .undef(undef)
  );

  // Computed program-memory contents.
  function automatic logic [15:0] memf(input logic [22:0] w);
    logic [7:0] hi, lo;
    hi = w[7:0] ^ w[22:15] ^ 8'h5A;
    lo = w[15:8] + {w[6:0], 1'b1};
    return {hi, lo};
  endfunction

  // Environment: register file, extension register, memory port.
  assign rf_rdata_lo = rf[rf_raddr_lo];
  assign rf_rdata_hi = rf[rf_raddr_hi];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 8'(i * 13 + 1);
      ext_reg  <= '0;
      pm_rdata <= '0;
    end else begin
      if (pm_req) pm_rdata <= memf(pm_addr);
      if (pre_we) begin
        rf[30]  <= pre_lo;
        rf[31]  <= pre_hi;
        ext_reg <= pre_ext;
      end
      if (rf_we[0]) rf[rf_waddr[4:0]]   <= rf_wdata[7:0];
      if (rf_we[1]) rf[rf_waddr[9:5]]   <= rf_wdata[15:8];
      if (rf_we[2]) rf[rf_waddr[14:10]] <= rf_wdata[23:16];
      if (ext_we)   ext_reg <= ext_wdata;
    end
  end

  // Behavioural reference model.
  int          phase = 0;
  bit          mill = 1'b0;
  bit          mund = 1'b0;
  logic [22:0] mwaddr = '0;
  logic [7:0]  mrf [32];
  logic [7:0]  mext = '0;
  string       mtag = "R1";
  int          mform, md;
  logic [23:0] mp, mpn;
  logic [15:0] mwd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mrf[i] = 8'(i * 13 + 1);
      mext  = '0;
      phase = 0;
      mill  = 1'b0;
      mund  = 1'b0;
    end else begin
      if (pre_we) begin
        mrf[30] = pre_lo;
        mrf[31] = pre_hi;
        mext    = pre_ext;
      end
      case (phase)
        0: if (op_valid) begin
          if (op_code == 16'h95D8) mform = 1;
          else if ((op_code & 16'hFE0F) == 16'h9006) mform = 2;
          else if ((op_code & 16'hFE0F) == 16'h9007) mform = 3;
          else mform = 0;
          mill = (mform == 0);
          mund = 1'b0;
          if (mform == 0) mtag = "R9";
          else begin
            md     = (mform == 1) ? 0 : int'(op_code[8:4]);
            mp     = {mext, mrf[31], mrf[30]};
            mwaddr = mp[23:1];
            mwd    = memf(mp[23:1]);
            mrf[md] = mp[0] ? mwd[15:8] : mwd[7:0];
            mtag   = (mform == 1) ? "R2/R6" : (mform == 2) ? "R3/R6" : "R4/R7";
            if (mform == 3) begin
              mpn     = mp + 24'd1;
              mrf[30] = mpn[7:0];
              mrf[31] = mpn[15:8];
              mext    = mpn[23:16];
              if (md >= 30) begin
                mund = 1'b1;
                mtag = "R8";
              end
            end
          end
          phase = 1;
        end
        1: phase = mill ? 0 : 2;
        2: phase = 3;
        default: phase = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, half a period after each edge.
  always @(negedge clk) begin
    chk("R1 op_ready", 32'(op_ready), 32'(phase == 0));
    chk("R1 busy", 32'(busy), 32'(phase != 0));
    chk("R9 illegal", 32'(illegal), 32'(phase == 1 && mill));
    chk("R5 pm_req", 32'(pm_req), 32'(phase == 2));
    if (phase == 2) chk("R5 pm_addr", 32'(pm_addr), 32'(mwaddr));
    chk("R10 done", 32'(done), 32'(phase == 3));
    chk("R8 undef", 32'(undef), 32'(phase == 3 && mund));
    if (rst_n && phase == 0) begin
      int bad = -1;
      for (int i = 0; i < 32; i++) if (rf[i] !== mrf[i] && bad < 0) bad = i;
      if (bad >= 0) chk({mtag, " register"}, {24'(bad), rf[bad]}, {24'(bad), mrf[bad]});
      else          chk({mtag, " register"}, 32'd0, 32'd0);
      chk({mtag, " ext"}, 32'(ext_reg), 32'(mext));
    end
  end

  task automatic setp(input logic [7:0] e, input logic [15:0] p);
    pre_ext = e; pre_hi = p[15:8]; pre_lo = p[7:0]; pre_we = 1'b1;
    @(posedge clk); #1;
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic [15:0] op);
    bit r;
    op_valid = 1'b1;
    op_code  = op;
    forever begin
      @(negedge clk); r = op_ready;
      @(posedge clk);
      if (r) break;
    end
    #1;
  endtask

  task automatic one(input logic [15:0] op);
    issue(op);
    op_valid = 1'b0;
    op_code  = 16'hFFFF;
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic run_all();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    setp(8'h00, 16'h1234); one(16'h95D8);      // R2, low lane
    setp(8'h03, 16'h4567); one(16'h9056);      // R3, R6 high lane, d=5
    setp(8'h12, 16'hFFFF); one(16'h9117);      // R4, R7 carry into ext
    setp(8'hFF, 16'hFFFF); one(16'h9027);      // R7 full wrap
    setp(8'h40, 16'h00FE); one(16'h91E7);      // R8 dest r30
    setp(8'h40, 16'h01FF); one(16'h91F7);      // R8 dest r31 with carry
    one(16'h1234);                              // R9
    one(16'h95D9);                              // R9
    one(16'h9008);                              // R9
    setp(8'h7E, 16'hFFFE);                      // R1 back-to-back under back-pressure
    issue(16'h9107); issue(16'h9107); issue(16'h9107); issue(16'h95D8);
    one(16'h9006);                              // R3 d=0
    setp(8'h05, 16'h0A0A); one(16'h91F6);       // R3 d=31 keep
  endtask

  initial begin
    fork
      run_all();
      begin repeat (20000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: act=hung exp=idle");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule